// File: doc/BRIEF.md
# Split Serial-Access Video Buffer

This block is the serial side of a dual-port video memory. It watches a set of active-low control strobes and classifies each row-strobe fall. When a read transfer is recognised, it copies parallel row data from a wide row-data bus into a serial register, takes a start location (the tap) from the column address, and then streams one location per rising edge of the serial clock onto a serial data port.

The serial register is split into a lower half and an upper half. A split read transfer refills only the half that is not being read, while the pointer keeps streaming the other half. When the pointer reaches the last location of its half and a split load is waiting, it jumps to the tap stored by that split load in the other half. A status output shows which half is being read.

All strobes and the serial clock are sampled on the block clock `clk`. Edges are found by comparing each sample with the one before it. The location width and the row length are parameters. The row length must be a power of two.

Top module: `vsam_split_buffer`

## Requirements
- R1: After reset the serial port is not in output mode. `serDataEn` is 0, `serData` is 0 and `upperActive` is 0.
- R2: A row-strobe fall starts a transfer only if `xferN` is already low in the sample where the fall is seen. If `xferN` is high at that point, the serial register and the pointer stay unchanged.
- R3: A transfer with `dirWeN` high and `splitSel` low at the row-strobe fall is a full read transfer. It loads every location `i` from `rowData[i*DATA_W +: DATA_W]`, sets the pointer to the full column address, cancels any pending split load and turns on output mode.
- R4: A row-strobe fall with `dirWeN` low is not a read transfer and changes nothing at the ports.
- R5: A transfer with `dirWeN` high and `splitSel` high is a split read transfer. It loads only the half the pointer is not in, and the half it is in keeps streaming unchanged. It stores the pending tap as that other half plus column bits `AW-2:0`; column bit `AW-1` is ignored.
- R6: The tap is taken at the column-strobe fall. If the row strobe rises before the column strobe has fallen, the transfer is dropped and nothing is loaded.
- R7: The load happens in the first sample with `xferN` high after the column strobe has fallen. Until then the ports still show the old contents.
- R8: `upperActive` is 0 while the pointer is in the lower half (locations 0 to ROW_LEN/2-1) and 1 while it is in the upper half.
- R9: Each rising edge of `serClk` advances the pointer by one location, whatever the level of `serEnN`.
- R10: `serEnN` only gates the output. `serDataEn` is 1 exactly when output mode is on and `serEnN` is low. In that state `serData` is the location under the pointer; otherwise `serData` is 0.
- R11: An advance from the last location of a half jumps to the pending split tap if a split load is waiting, and that clears the pending load. With no pending load the pointer moves to the next location, and the last location of the register wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rowStrobeN | input | 1 | Row strobe, active low; its fall starts a cycle |
| colStrobeN | input | 1 | Column strobe, active low; its fall captures the tap |
| xferN | input | 1 | Transfer request, active low; its rise commits the load |
| dirWeN | input | 1 | Transfer direction; high selects a read transfer |
| splitSel | input | 1 | High selects a split transfer, low a full transfer |
| colAddr | input | AW | Column address carrying the tap |
| rowData | input | ROW_LEN*DATA_W | Parallel row data, location i at bits i*DATA_W |
| serClk | input | 1 | Serial clock; each rising edge advances the pointer |
| serEnN | input | 1 | Serial output enable, active low |
| serData | output | DATA_W | Location under the pointer, or 0 when disabled |
| serDataEn | output | 1 | High while the serial port drives data |
| upperActive | output | 1 | High while the pointer is in the upper half |

## Verification
A wrong pointer shows up at once on `serData`. It gives the wrong word in the first enabled sample after an advance or a load. If it is in the wrong half, `upperActive` flips in the same sample. A wrong pending tap or pending flag stays hidden until the pointer leaves the end of a half, so the bench streams across both half boundaries after a split load. A half reloaded by mistake shows only when the pointer later wraps back into that half, so the bench checks the first word after the wrap. A transfer classified wrongly shows in the sample after its commit point, because the word under the pointer changes or fails to change.

// File: rtl/vsam_pkg.sv
package vsam_pkg;

  // Transfer sequencing states
  typedef enum logic [1:0] {
    XF_IDLE     = 2'd0,
    XF_WAIT_COL = 2'd1,
    XF_WAIT_REL = 2'd2
  } xferState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic commitFull;   // load whole register, set pointer to tap
    logic commitSplit;  // load inactive half, arm pending tap
    logic advance;      // serial clock rising edge
  } vsamStrobe_t;

endpackage

// File: rtl/vsam_ctrl.sv
module vsam_ctrl
  import vsam_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rowStrobeN,
  input  logic          colStrobeN,
  input  logic          xferN,
  input  logic          dirWeN,
  input  logic          splitSel,
  input  logic          serClk,
  input  logic [AW-1:0] colAddr,
  output vsamStrobe_t   strobe,
  output logic [AW-1:0] tap
);

  logic       rowQ, colQ, scQ;
  logic       rowFall, colFall;
  logic       splitQ;
  logic [AW-1:0] tapQ;
  xferState_e state, nextState;

  assign rowFall = rowQ & ~rowStrobeN;
  assign colFall = colQ & ~colStrobeN;

  always_comb begin
    nextState = state;
    unique case (state)
      XF_IDLE:     if (rowFall && !xferN && dirWeN) nextState = XF_WAIT_COL;
      XF_WAIT_COL: if (rowStrobeN)                  nextState = XF_IDLE;
                   else if (colFall)                nextState = XF_WAIT_REL;
      XF_WAIT_REL: if (xferN)                       nextState = XF_IDLE;
      default:                                      nextState = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= 1'b1;
      colQ   <= 1'b1;
      scQ    <= 1'b0;
      state  <= XF_IDLE;
      splitQ <= 1'b0;
      tapQ   <= '0;
    end else begin
      rowQ  <= rowStrobeN;
      colQ  <= colStrobeN;
      scQ   <= serClk;
      state <= nextState;
      if (state == XF_IDLE && nextState == XF_WAIT_COL) splitQ <= splitSel;
      if (state == XF_WAIT_COL && nextState == XF_WAIT_REL) tapQ <= colAddr;
    end
  end

  always_comb begin
    strobe.commitFull  = (state == XF_WAIT_REL) && xferN && !splitQ;
    strobe.commitSplit = (state == XF_WAIT_REL) && xferN &&  splitQ;
    strobe.advance     = serClk && !scQ;
  end

  assign tap = tapQ;

endmodule

// File: rtl/vsam_datapath.sv
module vsam_datapath
  import vsam_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int ROW_LEN = 512,
  localparam int AW     = $clog2(ROW_LEN),
  localparam int HALF   = ROW_LEN / 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  vsamStrobe_t               strobe,
  input  logic [AW-1:0]             tap,
  input  logic [ROW_LEN*DATA_W-1:0] rowData,
  input  logic                      serEnN,
  output logic [DATA_W-1:0]         serData,
  output logic                      serDataEn,
  output logic [AW-1:0]             ptr,
  output logic                      pending,
  output logic [AW-1:0]             pendTap
);

  logic [ROW_LEN-1:0][DATA_W-1:0] sam;
  logic [ROW_LEN-1:0]             loadMask;
  logic                           outMode;
  logic                           loadUpper;
  logic                           atHalfEnd;

  assign loadUpper = ~ptr[AW-1];
  assign atHalfEnd = &ptr[AW-2:0];

  for (genvar i = 0; i < ROW_LEN; i++) begin : g_mask
    localparam bit UpperLoc = (i >= HALF);
    assign loadMask[i] = strobe.commitFull |
                         (strobe.commitSplit & (loadUpper == UpperLoc));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ROW_LEN; i++) begin
      if (loadMask[i]) sam[i] <= rowData[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      pending <= 1'b0;
      pendTap <= '0;
      outMode <= 1'b0;
    end else if (strobe.commitFull) begin
      ptr     <= tap;
      pending <= 1'b0;
      outMode <= 1'b1;
    end else begin
      if (strobe.advance) begin
        if (pending && atHalfEnd) begin
          ptr     <= pendTap;
          pending <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
      if (strobe.commitSplit) begin
        pendTap <= {loadUpper, tap[AW-2:0]};
        pending <= 1'b1;
        outMode <= 1'b1;
      end
    end
  end

  assign serDataEn = outMode & ~serEnN;
  assign serData   = serDataEn ? sam[ptr] : '0;

endmodule

// File: rtl/vsam_split_buffer.sv
module vsam_split_buffer
  import vsam_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int ROW_LEN = 512,
  localparam int AW     = $clog2(ROW_LEN)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rowStrobeN,
  input  logic                      colStrobeN,
  input  logic                      xferN,
  input  logic                      dirWeN,
  input  logic                      splitSel,
  input  logic [AW-1:0]             colAddr,
  input  logic [ROW_LEN*DATA_W-1:0] rowData,
  input  logic                      serClk,
  input  logic                      serEnN,
  output logic [DATA_W-1:0]         serData,
  output logic                      serDataEn,
  output logic                      upperActive
);

  vsamStrobe_t   strobe;
  logic [AW-1:0] tap;
  logic [AW-1:0] ptr;
  logic          pending;
  logic [AW-1:0] pendTap;

  vsam_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .xferN(xferN), .dirWeN(dirWeN), .splitSel(splitSel), .serClk(serClk),
    .colAddr(colAddr), .strobe(strobe), .tap(tap)
  );

  vsam_datapath #(.DATA_W(DATA_W), .ROW_LEN(ROW_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tap(tap), .rowData(rowData),
    .serEnN(serEnN), .serData(serData), .serDataEn(serDataEn), .ptr(ptr),
    .pending(pending), .pendTap(pendTap)
  );

  assign upperActive = ptr[AW-1];

endmodule

// File: rtl/vsam_split_buffer_chk.sv
module vsam_split_buffer_chk
  import vsam_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int AW     = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              serEnN,
  input logic              serDataEn,
  input logic [DATA_W-1:0] serData,
  input vsamStrobe_t       strobe,
  input logic [AW-1:0]     tap,
  input logic [AW-1:0]     ptr,
  input logic              pending,
  input logic [AW-1:0]     pendTap
);

  // R10: disabled port carries no data
  a_r10_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    serEnN |-> (!serDataEn && serData == '0));

  // R3: full load puts pointer on the tap and drops the pending split
  a_r3_full_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitFull |=> (ptr == $past(tap) && !pending));

  // R11: end of half with pending split jumps to the pending tap
  a_r11_cross: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.commitFull && !strobe.commitSplit && pending && (&ptr[AW-2:0]))
    |=> (ptr == $past(pendTap) && !pending));

  // R9: plain advance steps by one
  a_r9_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.commitFull && !(pending && (&ptr[AW-2:0])))
    |=> (ptr == AW'($past(ptr) + 1'b1)));

  // R5: split load targets the other half
  a_r5_other_half: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitSplit && !strobe.advance)
    |=> (pending && pendTap[AW-1] != ptr[AW-1] && ptr == $past(ptr)));

  // R3 / R5: a commit is either full or split, never both
  a_r5_one_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.commitFull, strobe.commitSplit}));

endmodule

bind vsam_split_buffer vsam_split_buffer_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .serEnN(serEnN), .serDataEn(serDataEn),
  .serData(serData), .strobe(strobe), .tap(tap), .ptr(ptr),
  .pending(pending), .pendTap(pendTap)
);

// File: tb/vsam_split_buffer_bench.sv
module vsam_split_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int RL = 512;
  localparam int AW = 9;
  localparam int HL = RL / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowStrobeN = 1'b1, colStrobeN = 1'b1, xferN = 1'b1, dirWeN = 1'b1, splitSel = 1'b0;
  logic [AW-1:0] colAddr = '0;
  logic [RL*DW-1:0] rowData = '0;
  logic serClk = 1'b0, serEnN = 1'b0;
  logic [DW-1:0] serData;
  logic serDataEn, upperActive;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsam_split_buffer #(.DATA_W(DW), .ROW_LEN(RL)) u_vsam_split_buffer (
    .clk(clk), .rstN(rstN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .xferN(xferN), .dirWeN(dirWeN), .splitSel(splitSel), .colAddr(colAddr),
    .rowData(rowData), .serClk(serClk), .serEnN(serEnN), .serData(serData),
    .serDataEn(serDataEn), .upperActive(upperActive)
  );

  function automatic int pat(int seed, int loc);
    return (loc * 5 + seed * 3 + (loc >> 4)) & 15;
  endfunction

  // Behavioural reference model
  int mSam [RL];
  int mPtr, mPendTap, mTap, mSt;
  bit mPend, mOut, mSplit, mRowPrev, mColPrev, mScPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPtr = 0; mPendTap = 0; mTap = 0; mSt = 0;
      mPend = 0; mOut = 0; mSplit = 0;
      mRowPrev = 1; mColPrev = 1; mScPrev = 0;
    end else begin
      bit commit, adv, oldUpper;
      commit = (mSt == 2) && xferN;
      adv = serClk && !mScPrev;
      oldUpper = (mPtr >= HL);
      if (commit && !mSplit) begin
        for (int i = 0; i < RL; i++) mSam[i] = int'(rowData[i*DW +: DW]);
        mPtr = mTap; mPend = 0; mOut = 1;
      end else begin
        if (adv) begin
          if (mPend && (mPtr % HL) == HL - 1) begin
            mPtr = mPendTap; mPend = 0;
          end else mPtr = (mPtr + 1) % RL;
        end
        if (commit) begin
          for (int i = 0; i < HL; i++) begin
            int loc;
            loc = oldUpper ? i : i + HL;
            mSam[loc] = int'(rowData[loc*DW +: DW]);
          end
          mPendTap = (oldUpper ? 0 : HL) + (mTap % HL);
          mPend = 1; mOut = 1;
        end
      end
      case (mSt)
        0: if (mRowPrev && !rowStrobeN && !xferN && dirWeN) begin mSt = 1; mSplit = splitSel; end
        1: if (rowStrobeN) mSt = 0;
           else if (mColPrev && !colStrobeN) begin mTap = int'(colAddr); mSt = 2; end
        2: if (xferN) mSt = 0;
        default: mSt = 0;
      endcase
      mRowPrev = rowStrobeN; mColPrev = colStrobeN; mScPrev = serClk;
    end
  end

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Advance to a negedge and compare against the model
  task automatic step();
    bit en;
    @(negedge clk);
    if (rstN) begin
      en = mOut && !serEnN;
      check("R10 model enable", int'(serDataEn), int'(en));
      check("R8 model half flag", int'(upperActive), int'(mPtr >= HL));
      check("R9 model data", int'(serData), en ? mSam[mPtr] : 0);
    end
  endtask

  task automatic setRow(int seed);
    for (int i = 0; i < RL; i++) rowData[i*DW +: DW] = DW'(pat(seed, i));
  endtask

  task automatic xfer(input bit we, input bit split, input bit trLowAtRas,
                      input bit doCas, input int col, input int seed,
                      output int preEn, output int preData);
    step(); setRow(seed); xferN = !trLowAtRas; dirWeN = we; splitSel = split;
    step(); rowStrobeN = 1'b0;
    step(); colAddr = AW'(col); if (doCas) colStrobeN = 1'b0;
    step(); preEn = int'(serDataEn); preData = int'(serData); xferN = 1'b1;
    step(); rowStrobeN = 1'b1; colStrobeN = 1'b1;
    step(); step();
  endtask

  task automatic scPulses(int n);
    for (int k = 0; k < n; k++) begin
      step(); serClk = 1'b1;
      step(); serClk = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pe, pd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    check("R1 reset enable", int'(serDataEn), 0);
    check("R1 reset data", int'(serData), 0);
    check("R1 reset half", int'(upperActive), 0);

    // R3 / R7: full transfer, tap 5
    xfer(1'b1, 1'b0, 1'b1, 1'b1, 5, 1, pe, pd);
    check("R7 old state before release", pe, 0);
    check("R3 first word at tap", int'(serData), pat(1, 5));
    check("R3 output mode on", int'(serDataEn), 1);
    check("R8 lower half", int'(upperActive), 0);

    // R10 / R9: advance with output disabled
    serEnN = 1'b1;
    scPulses(3);
    check("R10 disabled enable", int'(serDataEn), 0);
    check("R10 disabled data", int'(serData), 0);
    serEnN = 1'b0;
    step();
    check("R9 advance while disabled", int'(serData), pat(1, 8));

    // R2: xferN high at row fall
    xfer(1'b1, 1'b0, 1'b0, 1'b1, 20, 2, pe, pd);
    check("R2 no transfer", int'(serData), pat(1, 8));
    // R4: write direction ignored
    xfer(1'b0, 1'b0, 1'b1, 1'b1, 20, 2, pe, pd);
    check("R4 write ignored", int'(serData), pat(1, 8));
    // R6: no column strobe
    xfer(1'b1, 1'b0, 1'b1, 1'b0, 20, 2, pe, pd);
    check("R6 aborted transfer", int'(serData), pat(1, 8));

    // R5: split transfer, tap 4, while lower half streams
    xfer(1'b1, 1'b1, 1'b1, 1'b1, 4, 3, pe, pd);
    check("R5 active half continues", int'(serData), pat(1, 8));
    check("R5 half flag kept", int'(upperActive), 0);

    scPulses(HL - 1 - 8);
    check("R5 lower end word", int'(serData), pat(1, HL - 1));
    scPulses(1);
    check("R11 jump to pending tap", int'(serData), pat(3, HL + 4));
    check("R8 upper half", int'(upperActive), 1);

    scPulses(RL - 1 - (HL + 4));
    check("R11 upper end word", int'(serData), pat(3, RL - 1));
    scPulses(1);
    check("R11 wrap to zero", int'(serData), pat(1, 0));
    check("R8 back to lower", int'(upperActive), 0);

    step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule